// File: doc/BRIEF.md
# Flash Command Sequencer with Reset Handling

This block decodes the command protocol that a microcontroller uses to drive a sectored flash array over a plain parallel write/read bus. A command is recognised only after two unlock writes with fixed address/data pairs. The cycle that follows them carries the command byte. The sequencer tracks the operating mode: read, program, bulk erase, sector erase, error, or recovery. It issues one-cycle program and erase requests to the array, and it models busy time with parameterised cycle counters. A ready output is low whenever the array is not in read mode.

Per-sector protection bits come from the programming side as an input. The microcontroller can read them at a fixed status address but cannot change them. A program or erase aimed at a protected sector is dropped, so the array keeps its contents and reads return the stored data. A test input models a failed program or erase and raises an error flag.

Two ways to return to read mode are provided, and they behave differently. The reset command acts according to the current mode: it does nothing during a program or bulk erase, it aborts a sector erase after a recovery interval, and it needs the same interval to clear an error. The reset pin aborts any busy mode and always goes through recovery.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command is accepted only after a write of AAh to address UNLK_A1 (default 0AAAh) followed by a write of 55h to UNLK_A2 (default 0554h). The next write is the command cycle. Any other write during unlocking returns the decoder to idle and has no other effect.
- R2: Command A0h puts the decoder into program setup. The next write starts a program: arr_we pulses for one cycle with that write's address and data, and ready is low for exactly PROG_CYC cycles.
- R3: Command 30h starts a sector erase of the sector given by the top SEC_W bits of the command cycle's address. arr_erase pulses with arr_erase_all=0 and a one-hot arr_mask, and ready is low for exactly SERASE_CYC cycles.
- R4: Command 10h starts a bulk erase. arr_erase pulses with arr_erase_all=1 and arr_mask equal to the inverse of prot_bits, and ready is low for exactly BULK_CYC cycles. If every sector is protected, the command is dropped.
- R5: A program or sector erase aimed at a protected sector is dropped. No request is issued, ready stays high, and rdata keeps returning arr_rdata.
- R6: In read mode, rdata at PROT_ADDR (default FF00h) returns prot_bits zero-extended to 8 bits. Writes to that address do not change it.
- R7: Reset command F0h in read mode with no error leaves the block ready, with no request issued.
- R8: Reset command F0h during a program or bulk erase is ignored, and the busy time is not changed.
- R9: Reset command F0h during a sector erase aborts it. Ready goes high exactly RECOV_CYC cycles after the command cycle.
- R10: fail_in asserted during a program or erase sets the error flag and holds the block busy, not ready, until a reset.
- R11: Reset command F0h while the error flag is set restores read mode exactly RECOV_CYC cycles later. The flag is cleared on that return.
- R12: A one-cycle abort_pin pulse clears a partial unlock. In any busy mode it starts a RECOV_CYC recovery, which ends in read mode with the error flag clear. In read mode it has no other effect.
- R13: After reset, ready is high. Whenever ready is low, rdata is the status byte: bit 7 = 0, bit 5 = error flag, all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data: array data, protection status or busy status |
| abort_pin | input | 1 | Reset pin, active-high pulse |
| fail_in | input | 1 | Simulated program/erase failure |
| prot_bits | input | NSEC | Per-sector protection, 1 = protected |
| arr_rdata | input | 8 | Read data from the array |
| ready | output | 1 | High in read mode |
| arr_we | output | 1 | One-cycle program request |
| arr_addr | output | ADDR_W | Program address |
| arr_wdata | output | 8 | Program data |
| arr_erase | output | 1 | One-cycle erase request |
| arr_erase_all | output | 1 | Erase request is a bulk erase |
| arr_mask | output | NSEC | Sectors to erase |

## Verification
The bench measures busy time to the exact cycle after a reset command lands in each mode. A design that let the reset command stall or shorten a program or bulk erase gives a wrong remaining count. So does one that returned from an aborted sector erase or an error at once, without the recovery interval. Broken unlock sequences and an abort pulse in the middle of an unlock are each followed by what would be a valid program write; a decoder that failed to reset would then issue a stray program request. Protected sectors are targeted by program, sector erase and bulk erase, where a design that ignored protection would issue a request or erase a protected sector. The status byte is read in error and after recovery, to catch an error flag that sticks or is never raised.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W     = 16,
  parameter int NSEC       = 8,
  parameter int PROG_CYC   = 2000,
  parameter int SERASE_CYC = 8000,
  parameter int BULK_CYC   = 16000,
  parameter int RECOV_CYC  = 5000,
  parameter logic [ADDR_W-1:0] UNLK_A1   = 16'h0AAA,
  parameter logic [ADDR_W-1:0] UNLK_A2   = 16'h0554,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              abort_pin,
  input  logic              fail_in,
  input  logic [NSEC-1:0]   prot_bits,
  input  logic [7:0]        arr_rdata,
  output logic              ready,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              arr_erase,
  output logic              arr_erase_all,
  output logic [NSEC-1:0]   arr_mask
);
  localparam int SEC_W = $clog2(NSEC);
  localparam int MAX_A = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
  localparam int MAX_B = (BULK_CYC > RECOV_CYC) ? BULK_CYC : RECOV_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {M_READ, M_PROG, M_BULK, M_SERASE, M_ERROR, M_RECOV} mode_t;
  typedef enum logic [1:0] {D_IDLE, D_UNL1, D_UNL2, D_PSET} dec_t;

  mode_t            mode;
  dec_t             dec;
  logic [CNT_W-1:0] cnt;
  logic             err;

  logic [SEC_W-1:0] wsec;
  logic             wprot, is_cmd, is_pdata, running, timed;

  assign wsec     = addr[ADDR_W-1 -: SEC_W];
  assign wprot    = prot_bits[wsec];
  assign is_cmd   = wr_en && (dec == D_UNL2);
  assign is_pdata = wr_en && (dec == D_PSET);
  assign running  = (mode == M_PROG) || (mode == M_BULK) || (mode == M_SERASE);
  assign timed    = running || (mode == M_RECOV);
  assign ready    = (mode == M_READ);

  assign rdata = !ready              ? {2'b00, err, 5'b00000} :
                 (addr == PROT_ADDR) ? 8'(prot_bits) : arr_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec <= D_IDLE;
    end else if (abort_pin) begin
      dec <= D_IDLE;
    end else if (wr_en) begin
      unique case (dec)
        D_IDLE: dec <= (addr == UNLK_A1 && wdata == 8'hAA) ? D_UNL1 : D_IDLE;
        D_UNL1: dec <= (addr == UNLK_A2 && wdata == 8'h55) ? D_UNL2 : D_IDLE;
        D_UNL2: dec <= (wdata == 8'hA0 && mode == M_READ) ? D_PSET : D_IDLE;
        default: dec <= D_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode          <= M_READ;
      cnt           <= '0;
      err           <= 1'b0;
      arr_we        <= 1'b0;
      arr_addr      <= '0;
      arr_wdata     <= '0;
      arr_erase     <= 1'b0;
      arr_erase_all <= 1'b0;
      arr_mask      <= '0;
    end else begin
      arr_we    <= 1'b0;
      arr_erase <= 1'b0;
      if (abort_pin) begin
        if (mode != M_READ) begin
          mode <= M_RECOV;
          cnt  <= CNT_W'(RECOV_CYC - 1);
        end
      end else if (fail_in && running) begin
        mode <= M_ERROR;
        err  <= 1'b1;
      end else if (is_cmd && wdata == 8'hF0 && (mode == M_SERASE || mode == M_ERROR)) begin
        mode <= M_RECOV;
        cnt  <= CNT_W'(RECOV_CYC - 1);
      end else if (is_cmd && mode == M_READ && wdata == 8'h10 && !(&prot_bits)) begin
        mode          <= M_BULK;
        cnt           <= CNT_W'(BULK_CYC - 1);
        arr_erase     <= 1'b1;
        arr_erase_all <= 1'b1;
        arr_mask      <= ~prot_bits;
      end else if (is_cmd && mode == M_READ && wdata == 8'h30 && !wprot) begin
        mode          <= M_SERASE;
        cnt           <= CNT_W'(SERASE_CYC - 1);
        arr_erase     <= 1'b1;
        arr_erase_all <= 1'b0;
        arr_mask      <= NSEC'(1) << wsec;
      end else if (is_pdata && mode == M_READ && !wprot) begin
        mode      <= M_PROG;
        cnt       <= CNT_W'(PROG_CYC - 1);
        arr_we    <= 1'b1;
        arr_addr  <= addr;
        arr_wdata <= wdata;
      end else if (timed) begin
        if (cnt == '0) begin
          if (mode == M_RECOV) err <= 1'b0;
          mode <= M_READ;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int NSEC  = 8,
  parameter int SEC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             err,
  input logic [7:0]       rdata,
  input logic             abort_pin,
  input logic [NSEC-1:0]  prot_bits,
  input logic             arr_we,
  input logic [SEC_W-1:0] arr_sec,
  input logic             arr_erase,
  input logic             arr_erase_all,
  input logic [NSEC-1:0]  arr_mask
);
  a_r2_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !ready);

  a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);

  a_r5_we_unprot: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !prot_bits[arr_sec]);

  a_r4_erase_unprot: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> ((arr_mask & prot_bits) == '0));

  a_r3_sec_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_erase && !arr_erase_all) |-> ($countones(arr_mask) == 1));

  a_r13_status_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (rdata[7:6] == 2'b00 && rdata[4:0] == 5'b00000));

  a_r10_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ready);

  a_r12_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pin |=> (!arr_we && !arr_erase));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.NSEC(NSEC), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .err(err), .rdata(rdata),
  .abort_pin(abort_pin), .prot_bits(prot_bits), .arr_we(arr_we),
  .arr_sec(arr_addr[ADDR_W-1 -: SEC_W]), .arr_erase(arr_erase),
  .arr_erase_all(arr_erase_all), .arr_mask(arr_mask)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int AW = 16, NS = 8;
  localparam int PC = 30, SC = 40, BC = 50, RC = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, abort_pin = 0, fail_in = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, arr_wdata;
  logic [NS-1:0] prot_bits = 8'b1000_0100, arr_mask;
  logic [7:0] arr_rdata = 8'h5A;
  logic ready, arr_we, arr_erase, arr_erase_all;
  logic [AW-1:0] arr_addr;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .NSEC(NS), .PROG_CYC(PC), .SERASE_CYC(SC),
    .BULK_CYC(BC), .RECOV_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .abort_pin(abort_pin), .fail_in(fail_in),
    .prot_bits(prot_bits), .arr_rdata(arr_rdata), .ready(ready),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_erase(arr_erase), .arr_erase_all(arr_erase_all), .arr_mask(arr_mask));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cmd(input logic [AW-1:0] a, input logic [7:0] d);
    wr(16'h0AAA, 8'hAA);
    wr(16'h0554, 8'h55);
    wr(a, d);
  endtask

  task automatic pulse_pin();
    abort_pin = 1; @(negedge clk); abort_pin = 0;
  endtask

  task automatic pulse_fail();
    fail_in = 1; @(negedge clk); fail_in = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (ready == 0 && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_state();
    addr = 16'h0000;
    eq("R13 ready after reset", ready, 1);
    eq("R13 no request after reset", {arr_we, arr_erase}, 0);
    eq("R13 read data after reset", rdata, 8'h5A);
  endtask

  task automatic t_bad_unlock();
    wr(16'h0AAA, 8'hAB); wr(16'h0554, 8'h55); wr(16'h0AAA, 8'hA0); wr(16'h2000, 8'h33);
    eq("R1 wrong unlock data no program", arr_we, 0);
    eq("R1 wrong unlock data ready", ready, 1);
    wr(16'h0AAA, 8'hAA); wr(16'h0556, 8'h55); wr(16'h6000, 8'h30);
    eq("R1 wrong unlock addr no erase", arr_erase, 0);
    eq("R1 wrong unlock addr ready", ready, 1);
  endtask

  task automatic t_program();
    int n;
    cmd(16'h0AAA, 8'hA0); wr(16'h2010, 8'h3C);
    eq("R2 program strobe", arr_we, 1);
    eq("R2 program addr", arr_addr, 16'h2010);
    eq("R2 program data", arr_wdata, 8'h3C);
    eq("R13 busy status", rdata, 8'h00);
    busy_len(n);
    eq("R2 program busy cycles", n, PC);
  endtask

  task automatic t_protected();
    cmd(16'h0AAA, 8'hA0); wr(16'h4000, 8'h11);
    eq("R5 protected program dropped", arr_we, 0);
    eq("R5 protected program ready", ready, 1);
    eq("R5 protected read data", rdata, 8'h5A);
    cmd(16'h4000, 8'h30);
    eq("R5 protected erase dropped", arr_erase, 0);
    eq("R5 protected erase ready", ready, 1);
  endtask

  task automatic t_prot_status();
    addr = 16'hFF00; #1;
    eq("R6 protection status read", rdata, 8'h84);
    wr(16'hFF00, 8'h00);
    eq("R6 protection write ignored", rdata, 8'h84);
    eq("R6 ready after status write", ready, 1);
  endtask

  task automatic t_sector_erase();
    int n;
    cmd(16'h6000, 8'h30);
    eq("R3 sector erase strobe", arr_erase, 1);
    eq("R3 sector erase not bulk", arr_erase_all, 0);
    eq("R3 sector erase mask", arr_mask, 8'h08);
    busy_len(n);
    eq("R3 sector erase busy cycles", n, SC);
  endtask

  task automatic t_bulk();
    int n;
    cmd(16'h0AAA, 8'h10);
    eq("R4 bulk strobe", arr_erase, 1);
    eq("R4 bulk flag", arr_erase_all, 1);
    eq("R4 bulk mask", arr_mask, 8'h7B);
    busy_len(n);
    eq("R4 bulk busy cycles", n, BC);
    prot_bits = 8'hFF;
    cmd(16'h0AAA, 8'h10);
    eq("R4 all protected bulk dropped", arr_erase, 0);
    eq("R4 all protected ready", ready, 1);
    prot_bits = 8'b1000_0100;
  endtask

  task automatic t_reset_cmd_read();
    cmd(16'h0AAA, 8'hF0);
    eq("R7 reset cmd in read ready", ready, 1);
    eq("R7 reset cmd no request", {arr_we, arr_erase}, 0);
  endtask

  task automatic t_reset_cmd_ignored();
    int n;
    cmd(16'h0AAA, 8'hA0); wr(16'h2000, 8'h01);
    cmd(16'h0AAA, 8'hF0);
    busy_len(n);
    eq("R8 reset during program ignored", n, PC - 3);
    cmd(16'h0AAA, 8'h10);
    cmd(16'h0AAA, 8'hF0);
    busy_len(n);
    eq("R8 reset during bulk ignored", n, BC - 3);
  endtask

  task automatic t_reset_cmd_serase();
    int n;
    cmd(16'h6000, 8'h30);
    repeat (5) @(negedge clk);
    cmd(16'h0AAA, 8'hF0);
    busy_len(n);
    eq("R9 sector erase abort recovery", n, RC);
  endtask

  task automatic t_error();
    int n;
    cmd(16'h0AAA, 8'hA0); wr(16'h2000, 8'h02);
    pulse_fail();
    eq("R10 error status byte", rdata, 8'h20);
    repeat (PC + 20) @(negedge clk);
    eq("R10 error holds busy", ready, 0);
    cmd(16'h0AAA, 8'hF0);
    eq("R11 error visible in recovery", rdata, 8'h20);
    busy_len(n);
    eq("R11 error reset recovery", n, RC);
    cmd(16'h0AAA, 8'hA0); wr(16'h2000, 8'h03);
    eq("R11 error flag cleared", rdata, 8'h00);
    busy_len(n);
    eq("R11 program after error", n, PC);
  endtask

  task automatic t_pin();
    int n;
    wr(16'h0AAA, 8'hAA);
    pulse_pin();
    eq("R12 pin in read keeps ready", ready, 1);
    wr(16'h0554, 8'h55); wr(16'h0AAA, 8'hA0); wr(16'h2000, 8'h77);
    eq("R12 pin clears partial unlock", arr_we, 0);
    cmd(16'h6000, 8'h30);
    repeat (3) @(negedge clk);
    pulse_pin();
    busy_len(n);
    eq("R12 pin aborts erase recovery", n, RC);
    cmd(16'h0AAA, 8'hA0); wr(16'h2000, 8'h04);
    pulse_fail();
    pulse_pin();
    busy_len(n);
    eq("R12 pin clears error recovery", n, RC);
    cmd(16'h0AAA, 8'hA0); wr(16'h2000, 8'h05);
    eq("R12 error cleared by pin", rdata, 8'h00);
    busy_len(n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_bad_unlock();
    t_program();
    t_protected();
    t_prot_status();
    t_sector_erase();
    t_bulk();
    t_reset_cmd_read();
    t_reset_cmd_ignored();
    t_reset_cmd_serase();
    t_error();
    t_pin();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule